// File: doc/BRIEF.md
# Event-Matched Multi-Output PWM Timer

This block is a free-running timer that drives a bank of pulse outputs. A 32-bit counter, advanced once every prescale+1 clocks, is compared against a set of match registers. Each event watches one match register, and fires when that register equals the counter while the counter advances. Every output has two event masks. Any firing event in its set mask drives it high, and any firing event in its clear mask drives it low. A 2-bit resolution code per output decides the result when both masks see an event in the same cycle.

Software sets the period by pointing one event at a match value of N-1 and naming that event in the limit mask. The counter then runs 0..N-1 and returns to 0. A second event, with match value D, clears the output. Each match register has a reload register, which is copied into it whenever the counter wraps. This lets new period and duty values take effect at a period boundary. A bidirectional mode counts up to the limit and back down to 0. All state is reached through a simple write port and a combinational read port.

Top module: `evpwm_timer`

## Requirements
- R1: After reset the counter reads 0, all outputs are 0, the control word reads 0x4 (halted), and the limit mask, set masks and clear masks read 0.
- R2: While the halt bit (control bit 2) is 1, the counter keeps its value. A write to the counter address still loads the written value.
- R3: The counter advances once every prescale+1 clocks, where prescale is control bits 12:5.
- R4: An event fires only when its control word has combine field (bits 13:12) equal to 1. It compares the match register chosen by bits 3:0 against the counter. Any other combine value, including a cleared word, disables the event.
- R5: An output goes high one clock after the count at which an event in its set mask fires, and low one clock after an event in its clear mask fires. An output whose masks are both 0 keeps its level.
- R6: When bidirectional mode is off and an event in the limit mask fires, the next count is 0 instead of an increment. A period event matching N-1 gives a cycle of N counts. Otherwise the counter increments by 1.
- R7: When set and clear fire together on output k, the resolution field at bits 2k+1:2k applies: 0 holds the level, 1 sets, 2 clears, 3 toggles.
- R8: On each wrap, every match register takes the value of its reload register, unless the no-reload bit (config bit 7) is 1.
- R9: With control bit 4 set, the counter counts up until a limit event fires, then counts down to 0, then counts up again. Reload happens on the turn at 0.
- R10: The register map, by byte address, is: 0x00 config (bit 0 unified, bit 7 no-reload), 0x01 control, 0x02 limit mask, 0x03 resolution, 0x04 counter (read/write), 0x05 outputs (read). Per-index blocks are 0x1n match, 0x2n reload, 0x3n event control, 0x4n set mask and 0x5n clear mask, where n is the event or output index. Every writable field reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_out | output | 16 | Registered pulse outputs |

## Verification
Some behaviours are checked by assertions on every cycle:
- a halted counter holds its value;
- the counter holds between prescaler ticks;
- in one-way counting, the counter either increments or returns to 0 on a limit event;
- the outputs change only in cycles where an event fires;
- a set-on-conflict output ends high.

Other behaviours only the bench scenarios can show:
- the duty-cycle shape produced by a sweep of periods and duties across four outputs;
- toggle and hold resolution over successive wraps;
- reload changing the period, and the no-reload bit preventing it;
- the up/down sequence;
- disabled events leaving outputs stuck high.

// File: rtl/evpwm_timer.sv
module evpwm_timer #(
  parameter int NOUT = 16,
  parameter int NEV  = 16,
  parameter int CW   = 32,
  parameter int PSW  = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NOUT-1:0] pwm_out
);
  localparam int SELW = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int RESW = 2 * NOUT;
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_LIM = AW'(2);
  localparam logic [AW-1:0] A_RES = AW'(3);
  localparam logic [AW-1:0] A_CNT = AW'(4);
  localparam logic [AW-1:0] A_OUT = AW'(5);
  localparam logic [AW-5:0] G_MAT = (AW-4)'(1);
  localparam logic [AW-5:0] G_REL = (AW-4)'(2);
  localparam logic [AW-5:0] G_EVC = (AW-4)'(3);
  localparam logic [AW-5:0] G_SET = (AW-4)'(4);
  localparam logic [AW-5:0] G_CLR = (AW-4)'(5);

  logic cfg_unify, cfg_norel, halt, bidir, dir_up;
  logic [PSW-1:0] presc, pc;
  logic [CW-1:0] cnt;
  logic [NEV-1:0] limit_m, fire;
  logic [RESW-1:0] res;
  logic [NEV-1:0][CW-1:0] match_r, reload_r;
  logic [NEV-1:0][SELW-1:0] ev_sel;
  logic [NEV-1:0][1:0] ev_comb;
  logic [NOUT-1:0][NEV-1:0] set_m, clr_m;
  logic [NOUT-1:0] out_q;

  wire [AW-5:0] wgrp = wr_addr[AW-1:4];
  wire [3:0]    widx = wr_addr[3:0];
  wire [AW-5:0] rgrp = rd_addr[AW-1:4];
  wire [3:0]    ridx = rd_addr[3:0];

  wire tick       = !halt && (pc == presc);
  wire cnt_wr     = wr_en && (wr_addr == A_CNT);
  wire limit_hit  = |(fire & limit_m);
  wire reload_now = tick && (bidir ? (!dir_up && cnt == '0) : limit_hit);

  assign pwm_out = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_unify <= 1'b0;
      cfg_norel <= 1'b0;
      halt      <= 1'b1;
      bidir     <= 1'b0;
      presc     <= '0;
      limit_m   <= '0;
      res       <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG: begin
          cfg_unify <= wr_data[0];
          cfg_norel <= wr_data[7];
        end
        A_CTL: begin
          halt  <= wr_data[2];
          bidir <= wr_data[4];
          presc <= wr_data[5 +: PSW];
        end
        A_LIM:   limit_m <= wr_data[NEV-1:0];
        A_RES:   res     <= wr_data[RESW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pc     <= '0;
      dir_up <= 1'b1;
    end else if (cnt_wr) begin
      cnt    <= wr_data[CW-1:0];
      pc     <= '0;
      dir_up <= 1'b1;
    end else if (!halt) begin
      pc <= tick ? '0 : pc + 1'b1;
      if (tick) begin
        if (!bidir) begin
          dir_up <= 1'b1;
          cnt    <= limit_hit ? '0 : cnt + 1'b1;
        end else if (dir_up) begin
          if (limit_hit) begin
            dir_up <= 1'b0;
            cnt    <= (cnt == '0) ? cnt : cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          dir_up <= 1'b1;
          cnt    <= CW'(1);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    wire hit_mat = wr_en && wgrp == G_MAT && widx == 4'(e);
    wire hit_rel = wr_en && wgrp == G_REL && widx == 4'(e);
    wire hit_evc = wr_en && wgrp == G_EVC && widx == 4'(e);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_r[e]  <= '0;
        reload_r[e] <= '0;
        ev_sel[e]   <= '0;
        ev_comb[e]  <= '0;
      end else begin
        if (hit_mat)                      match_r[e] <= wr_data[CW-1:0];
        else if (reload_now && !cfg_norel) match_r[e] <= reload_r[e];
        if (hit_rel) reload_r[e] <= wr_data[CW-1:0];
        if (hit_evc) begin
          ev_sel[e]  <= wr_data[SELW-1:0];
          ev_comb[e] <= wr_data[13:12];
        end
      end
    end

    assign fire[e] = tick && (ev_comb[e] == 2'd1) && (match_r[ev_sel[e]] == cnt);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    wire hit_set = wr_en && wgrp == G_SET && widx == 4'(o);
    wire hit_clr = wr_en && wgrp == G_CLR && widx == 4'(o);
    wire do_set  = |(fire & set_m[o]);
    wire do_clr  = |(fire & clr_m[o]);
    wire [1:0] code = res[2*o +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_m[o] <= '0;
        clr_m[o] <= '0;
        out_q[o] <= 1'b0;
      end else begin
        if (hit_set) set_m[o] <= wr_data[NEV-1:0];
        if (hit_clr) clr_m[o] <= wr_data[NEV-1:0];
        if (do_set && do_clr) begin
          case (code)
            2'd1:    out_q[o] <= 1'b1;
            2'd2:    out_q[o] <= 1'b0;
            2'd3:    out_q[o] <= ~out_q[o];
            default: out_q[o] <= out_q[o];
          endcase
        end else if (do_set) begin
          out_q[o] <= 1'b1;
        end else if (do_clr) begin
          out_q[o] <= 1'b0;
        end
      end
    end

    AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (do_set && do_clr && code == 2'd1) |=> out_q[o]); // R7
  end

  always_comb begin
    rd_data = '0;
    if (rgrp == '0) begin
      case (rd_addr)
        A_CFG:   rd_data = DW'({cfg_norel, 6'b0, cfg_unify});
        A_CTL:   rd_data = DW'({presc, bidir, 1'b0, halt, 2'b00});
        A_LIM:   rd_data = DW'(limit_m);
        A_RES:   rd_data = DW'(res);
        A_CNT:   rd_data = DW'(cnt);
        A_OUT:   rd_data = DW'(out_q);
        default: rd_data = '0;
      endcase
    end else if (int'(ridx) < NEV && rgrp == G_MAT) begin
      rd_data = DW'(match_r[ridx]);
    end else if (int'(ridx) < NEV && rgrp == G_REL) begin
      rd_data = DW'(reload_r[ridx]);
    end else if (int'(ridx) < NEV && rgrp == G_EVC) begin
      rd_data = (DW'(ev_comb[ridx]) << 12) | DW'(ev_sel[ridx]);
    end else if (int'(ridx) < NOUT && rgrp == G_SET) begin
      rd_data = DW'(set_m[ridx]);
    end else if (int'(ridx) < NOUT && rgrp == G_CLR) begin
      rd_data = DW'(clr_m[ridx]);
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cnt_wr) |=> $stable(cnt)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R3
  AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bidir && limit_hit && !cnt_wr) |=> (cnt == '0)); // R6
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bidir && !limit_hit && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1)); // R6
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> $stable(out_q)); // R5
endmodule

// File: tb/evpwm_timer_test.sv
module evpwm_timer_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, rd_addr = 8'h04;
  logic [31:0] wr_data = 0, rd_data;
  logic [15:0] pwm_out;
  int errs = 0, checks = 0;
  bit done = 0;

  evpwm_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1;
    v = rd_data;
    rd_addr = 8'h04;
  endtask

  task automatic sample(output int c, output logic [15:0] o);
    @(negedge clk); #1;
    c = int'(rd_data); o = pwm_out;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] o;
    int c, prev, wraps, mx, lastchg, nchg;
    bit wrapped;

    do_reset();
    // R1 reset state
    rd(8'h04, v); chk(v == 0, "R1 counter", v, 0);
    rd(8'h05, v); chk(v == 0, "R1 outputs", v, 0);
    chk(pwm_out == 0, "R1 pins", pwm_out, 0);
    rd(8'h01, v); chk(v == 32'h4, "R1 control", v, 4);
    rd(8'h02, v); chk(v == 0, "R1 limit", v, 0);
    rd(8'h43, v); chk(v == 0, "R1 set mask", v, 0);
    rd(8'h5C, v); chk(v == 0, "R1 clear mask", v, 0);

    // R10 register map readback
    wr(8'h00, 32'hFF);       rd(8'h00, v); chk(v == 32'h81, "R10 config", v, 32'h81);
    wr(8'h01, 32'h1FF4);     rd(8'h01, v); chk(v == 32'h1FF4, "R10 control", v, 32'h1FF4);
    wr(8'h02, 32'hA5A5);     rd(8'h02, v); chk(v == 32'hA5A5, "R10 limit", v, 32'hA5A5);
    wr(8'h03, 32'hDEADBEEF); rd(8'h03, v); chk(v == 32'hDEADBEEF, "R10 resolution", v, 32'hDEADBEEF);
    wr(8'h15, 32'h12345678); rd(8'h15, v); chk(v == 32'h12345678, "R10 match", v, 32'h12345678);
    wr(8'h25, 32'h9ABCDEF0); rd(8'h25, v); chk(v == 32'h9ABCDEF0, "R10 reload", v, 32'h9ABCDEF0);
    wr(8'h35, 32'h3FFF);     rd(8'h35, v); chk(v == 32'h300F, "R10 event ctrl", v, 32'h300F);
    wr(8'h47, 32'hBEEF);     rd(8'h47, v); chk(v == 32'hBEEF, "R10 set mask", v, 32'hBEEF);
    wr(8'h57, 32'h1234);     rd(8'h57, v); chk(v == 32'h1234, "R10 clear mask", v, 32'h1234);
    wr(8'h04, 32'h00C0FFEE); rd(8'h04, v); chk(v == 32'h00C0FFEE, "R10 R2 counter load while halted", v, 32'h00C0FFEE);

    // R5 R6 sweep of periods and duties on four outputs
    do_reset();
    for (int n = 3; n <= 8; n++) begin
      wr(8'h01, 32'h4); wr(8'h04, 0); wr(8'h02, 1); wr(8'h03, 32'h55);
      wr(8'h10, n - 1); wr(8'h20, n - 1); wr(8'h30, 32'h1000);
      for (int k = 0; k < 4; k++) begin
        wr(8'h11 + k, k % (n - 1)); wr(8'h21 + k, k % (n - 1));
        wr(8'h31 + k, 32'h1000 | (k + 1));
        wr(8'h40 + k, 1); wr(8'h50 + k, 1 << (k + 1));
      end
      wr(8'h01, 0);
      prev = -1; wrapped = 0;
      for (int s = 0; s < 4 * n; s++) begin
        sample(c, o);
        if (prev >= 0) chk(c == (prev + 1) % n, "R6 period count", c, (prev + 1) % n);
        if (prev == n - 1 && c == 0) wrapped = 1;
        if (wrapped)
          for (int k = 0; k < 4; k++)
            chk(o[k] == (c <= k % (n - 1)), "R5 duty shape", o[k], c <= k % (n - 1));
        chk(o[15:4] == 0, "R5 unmasked outputs hold", o, 0);
        prev = c;
      end
    end

    // R4 disabling duty events (combine field 2, then cleared word)
    wr(8'h31, 32'h2000); wr(8'h32, 0);
    for (int s = 0; s < 24; s++) begin
      sample(c, o);
      if (s >= 16) chk(o[1:0] == 2'b11, "R4 disabled clear event", o[1:0], 3);
    end

    // R7 conflict resolution codes 0..3 on outputs 0..3
    do_reset();
    wr(8'h02, 1);
    wr(8'h10, 3); wr(8'h20, 3); wr(8'h30, 32'h1000);
    wr(8'h11, 3); wr(8'h21, 3); wr(8'h31, 32'h1001);
    for (int k = 0; k < 4; k++) begin wr(8'h40 + k, 1); wr(8'h50 + k, 2); end
    wr(8'h03, 32'hE4);
    wr(8'h01, 0);
    prev = -1; wraps = 0;
    for (int s = 0; s < 24; s++) begin
      sample(c, o);
      if (prev == 3 && c == 0) wraps++;
      chk(o[0] == 0, "R7 hold code", o[0], 0);
      chk(o[1] == (wraps > 0), "R7 set code", o[1], wraps > 0);
      chk(o[2] == 0, "R7 clear code", o[2], 0);
      chk(o[3] == wraps[0], "R7 toggle code", o[3], wraps[0]);
      prev = c;
    end
    chk(wraps >= 5, "R7 wraps seen", wraps, 5);

    // R3 prescaler of 2: change every 3 clocks
    do_reset();
    wr(8'h01, 32'h40);
    prev = 0; lastchg = -1; nchg = 0;
    for (int s = 0; s < 30; s++) begin
      sample(c, o);
      if (c != prev) begin
        chk(c == prev + 1, "R3 step", c, prev + 1);
        if (lastchg >= 0) chk(s - lastchg == 3, "R3 spacing", s - lastchg, 3);
        lastchg = s; nchg++;
      end
      prev = c;
    end
    chk(nchg >= 9, "R3 change count", nchg, 9);

    // R2 halt freezes the counter
    wr(8'h01, 32'h4);
    rd(8'h04, v); c = int'(v);
    repeat (6) @(negedge clk);
    rd(8'h04, v); chk(int'(v) == c, "R2 halted", v, c);

    // R8 reload changes the period at the wrap
    do_reset();
    wr(8'h02, 1); wr(8'h10, 3); wr(8'h20, 5); wr(8'h30, 32'h1000);
    wr(8'h01, 0);
    mx = 0;
    for (int s = 0; s < 16; s++) begin sample(c, o); if (c > mx) mx = c; end
    wr(8'h01, 4);
    chk(mx == 5, "R8 reloaded period", mx, 5);
    rd(8'h10, v); chk(v == 5, "R8 match after reload", v, 5);

    // R8 no-reload bit keeps the match value
    do_reset();
    wr(8'h00, 32'h80);
    wr(8'h02, 1); wr(8'h10, 3); wr(8'h20, 5); wr(8'h30, 32'h1000);
    wr(8'h01, 0);
    mx = 0;
    for (int s = 0; s < 16; s++) begin sample(c, o); if (c > mx) mx = c; end
    wr(8'h01, 4);
    chk(mx == 3, "R8 no-reload period", mx, 3);
    rd(8'h10, v); chk(v == 3, "R8 no-reload match", v, 3);

    // R9 bidirectional count between 0 and the limit
    do_reset();
    wr(8'h02, 1); wr(8'h10, 3); wr(8'h20, 3); wr(8'h30, 32'h1000);
    wr(8'h01, 32'h10);
    prev = -1; mx = 0;
    for (int s = 0; s < 20; s++) begin
      sample(c, o);
      if (c > mx) mx = c;
      chk(c <= 3, "R9 range", c, 3);
      if (prev == 3) chk(c == 2, "R9 turn down", c, 2);
      if (prev == 0 && s > 1) chk(c == 1, "R9 turn up", c, 1);
      if (prev >= 0 && prev != c)
        chk(c == prev + 1 || c == prev - 1, "R9 unit step", c, prev);
      prev = c;
    end
    chk(mx == 3, "R9 peak", mx, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule